// File: doc/BRIEF.md
# Programmable Square-Wave Pin Driver

This block drives one open-drain output pin of a timekeeping device from a single 8-bit control byte. In static mode the pin sits at a level chosen by one bit of that byte. In wave mode the pin carries a 50% duty-cycle square wave at one of four rates: 1 Hz, 4.096 kHz, 8.192 kHz or 32.768 kHz. All four rates are taps of one free-running binary counter.

The block runs on a clock at 65.536 kHz, which is twice the 32.768 kHz oscillator rate. At that clock the fastest rate is the lowest bit of the counter, and every other rate is a higher bit. An external clock-halt input freezes the counter, and a running wave freezes with it.

A change of rate, or a switch from static to wave mode, never produces a short pulse on the pin. The pin keeps its present level until the newly selected counter bit next changes, and from then on it follows that bit. The control byte comes from a register elsewhere in the device. The oscillator and the bus access to that register are not part of this block.

Top module: `sqwave_out`

## Requirements
- R1: While reset is asserted, and directly after it, the pin is released (`pin_oe_o` = 0) and the rate counter is zero.
- R2: When control bit 4 (wave enable) is 0, the pin level equals control bit 7 one clock edge later. Level 0 means `pin_oe_o` = 1, and level 1 means `pin_oe_o` = 0.
- R3: Control bits 6, 5, 3 and 2 have no effect in either mode. Bits 1:0 have no effect in static mode. Bit 7 has no effect in wave mode.
- R4: In steady wave mode the pin level equals bit T of k, where k is the number of clock edges since reset at which the halt input was low. T is 15 for rate code 00 (1 Hz), 3 for 01 (4.096 kHz), 2 for 10 (8.192 kHz) and 0 for 11 (32.768 kHz). The rate code is control bits 1:0.
- R5: The output is open drain: `pin_oe_o` = 1 pulls the pin low, and `pin_oe_o` = 0 releases it to a logic 1.
- R6: After the rate code changes, or wave mode is entered at count k0, the level holds its previous value until the count reaches ((k0 >> T) + 1) << T for the new T. From that count on it follows R4.
- R7: While halt is high the counter does not advance and the wave level does not change. Counting resumes from the frozen value when halt falls.
- R8: Static mode follows bit 7 whether or not halt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 65.536 kHz clock, twice the oscillator rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Clock halt: freezes the rate counter |
| ctrl_i | input | 8 | Control byte: bit 7 static level, bit 4 wave enable, bits 1:0 rate code |
| pin_oe_o | output | 1 | Open-drain pull-down enable for the output pin |

## Verification
Every result of this block is due one clock edge after the input that causes it. A static level shows one edge after the control byte changes. A wave level shows on the same edge that advances the counter to the value that sets it. A rate switch completes on the edge that carries the counter to the next multiple of 2^T. The bench drives and samples on falling edges and keeps its own count of unhalted rising edges. At each sample it computes the expected level as either the held value or bit T of that count, with the switch point worked out arithmetically. It checks every cycle through each rate switch, through halt windows and through changes between static and wave mode.

// File: rtl/sqw_pkg.sv
`timescale 1ns/1ps
package sqw_pkg;

   localparam int CTRL_W    = 8;
   localparam int LEVEL_BIT = 7;
   localparam int WAVE_BIT  = 4;
   localparam int RATE_LSB  = 0;
   localparam int RATE_W    = 2;
   localparam int NUM_RATES = 1 << RATE_W;

   typedef enum logic [RATE_W-1:0] {
      RATE_SLOW = 2'b00,
      RATE_MID  = 2'b01,
      RATE_FAST = 2'b10,
      RATE_TOP  = 2'b11
   } rate_e;

   typedef struct packed {
      logic  level;
      logic  wave_en;
      rate_e rate;
   } ctrl_t;

   function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] b);
      ctrl_t c;
      c.level   = b[LEVEL_BIT];
      c.wave_en = b[WAVE_BIT];
      c.rate    = rate_e'(b[RATE_LSB +: RATE_W]);
      return c;
   endfunction

endpackage

// File: rtl/sqw_divider.sv
`timescale 1ns/1ps
module sqw_divider #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             halt_i,
   output logic [CNT_W-1:0] cnt_q_o,
   output logic [CNT_W-1:0] cnt_d_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cnt_d_o = halt_i ? cnt_q : cnt_q + ONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d_o;
   end

   assign cnt_q_o = cnt_q;

endmodule

// File: rtl/sqw_tap_sel.sv
`timescale 1ns/1ps
module sqw_tap_sel
   import sqw_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int TAPS [NUM_RATES] = '{15, 3, 2, 0}
) (
   input  logic [CNT_W-1:0] cnt_q_i,
   input  logic [CNT_W-1:0] cnt_d_i,
   input  rate_e            req_i,
   input  rate_e            act_i,
   output logic             req_next_o,
   output logic             req_flip_o,
   output logic             act_next_o
);

   logic [NUM_RATES-1:0] tap_now;
   logic [NUM_RATES-1:0] tap_nxt;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
      assign tap_now[i] = cnt_q_i[TAPS[i]];
      assign tap_nxt[i] = cnt_d_i[TAPS[i]];
   end

   always_comb begin
      req_next_o = tap_nxt[req_i];
      req_flip_o = tap_nxt[req_i] ^ tap_now[req_i];
      act_next_o = tap_nxt[act_i];
   end

endmodule

// File: rtl/sqw_level_ctl.sv
`timescale 1ns/1ps
module sqw_level_ctl
   import sqw_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  ctrl_t ctrl_i,
   input  logic  req_next_i,
   input  logic  req_flip_i,
   input  logic  act_next_i,
   output logic  level_o,
   output logic  run_o,
   output rate_e sel_o
);

   logic  level_q, level_d;
   logic  run_q, run_d;
   rate_e sel_q, sel_d;

   always_comb begin
      level_d = level_q;
      run_d   = run_q;
      sel_d   = sel_q;
      if (!ctrl_i.wave_en) begin
         run_d   = 1'b0;
         level_d = ctrl_i.level;
      end else if (run_q && (ctrl_i.rate == sel_q)) begin
         level_d = act_next_i;
      end else if (req_flip_i) begin
         run_d   = 1'b1;
         sel_d   = ctrl_i.rate;
         level_d = req_next_i;
      end else begin
         run_d   = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q <= 1'b1;
         run_q   <= 1'b0;
         sel_q   <= RATE_SLOW;
      end else begin
         level_q <= level_d;
         run_q   <= run_d;
         sel_q   <= sel_d;
      end
   end

   assign level_o = level_q;
   assign run_o   = run_q;
   assign sel_o   = sel_q;

endmodule

// File: rtl/sqwave_out.sv
`timescale 1ns/1ps
module sqwave_out
   import sqw_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int TAP_SLOW  = 15,
   parameter int TAP_MID   = 3,
   parameter int TAP_FAST  = 2,
   parameter int TAP_TOP   = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              halt_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic              pin_oe_o
);

   localparam int TAPS [NUM_RATES] = '{TAP_SLOW, TAP_MID, TAP_FAST, TAP_TOP};

   if (CNT_W < 2) begin : g_bad_width
      $error("sqwave_out: CNT_W must be at least 2");
   end
   if (TAP_SLOW >= CNT_W) begin : g_bad_slow
      $error("sqwave_out: TAP_SLOW must lie inside the counter");
   end
   if (!(TAP_SLOW > TAP_MID && TAP_MID > TAP_FAST && TAP_FAST > TAP_TOP && TAP_TOP >= 0)) begin : g_bad_order
      $error("sqwave_out: taps must fall strictly from slow to top rate");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             req_next, req_flip, act_next;
   logic             level_q, run_q;
   rate_e            sel_q;

   assign ctrl = decode_ctrl(ctrl_i);

   sqw_divider #(.CNT_W(CNT_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .halt_i  (halt_i),
      .cnt_q_o (cnt_q),
      .cnt_d_o (cnt_d)
   );

   sqw_tap_sel #(.CNT_W(CNT_W), .TAPS(TAPS)) u_tap (
      .cnt_q_i    (cnt_q),
      .cnt_d_i    (cnt_d),
      .req_i      (ctrl.rate),
      .act_i      (sel_q),
      .req_next_o (req_next),
      .req_flip_o (req_flip),
      .act_next_o (act_next)
   );

   sqw_level_ctl u_lvl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_i     (ctrl),
      .req_next_i (req_next),
      .req_flip_i (req_flip),
      .act_next_i (act_next),
      .level_o    (level_q),
      .run_o      (run_q),
      .sel_o      (sel_q)
   );

   // open drain: pull low only for a 0 level
   assign pin_oe_o = ~level_q;

endmodule

// File: rtl/sqwave_out_chk.sv
`timescale 1ns/1ps
module sqwave_out_chk #(
   parameter int CNT_W    = 16,
   parameter int TAP_SLOW = 15,
   parameter int TAP_MID  = 3,
   parameter int TAP_FAST = 2,
   parameter int TAP_TOP  = 0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             halt_i,
   input logic [7:0]       ctrl_i,
   input logic             pin_oe_o,
   input logic             level_q,
   input logic             run_q,
   input logic [1:0]       sel_q,
   input logic [CNT_W-1:0] cnt_q
);

   logic past_ok;
   logic sel_bit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   always_comb begin
      case (sel_q)
         2'b00:   sel_bit = cnt_q[TAP_SLOW];
         2'b01:   sel_bit = cnt_q[TAP_MID];
         2'b10:   sel_bit = cnt_q[TAP_FAST];
         default: sel_bit = cnt_q[TAP_TOP];
      endcase
   end

   // R2 / R8: static level reaches the pin one edge later
   assert_static_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && !$past(ctrl_i[4]) |-> pin_oe_o == !$past(ctrl_i[7]));

   // R4: a running wave follows its counter bit
   assert_wave_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> level_q == sel_bit);

   // R6: outside steady tracking the level moves only when the new rate is adopted
   assert_no_glitch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(ctrl_i[4]) && !($past(run_q) && $past(ctrl_i[1:0]) == $past(sel_q))
      && level_q != $past(level_q) |-> run_q && sel_q == $past(ctrl_i[1:0]));

   // R7: a halted wave keeps its level and its counter
   assert_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(halt_i) && $past(ctrl_i[4]) |-> $stable(level_q) && $stable(cnt_q));

endmodule

bind sqwave_out sqwave_out_chk #(
   .CNT_W(CNT_W), .TAP_SLOW(TAP_SLOW), .TAP_MID(TAP_MID),
   .TAP_FAST(TAP_FAST), .TAP_TOP(TAP_TOP)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .halt_i   (halt_i),
   .ctrl_i   (ctrl_i),
   .pin_oe_o (pin_oe_o),
   .level_q  (level_q),
   .run_q    (run_q),
   .sel_q    (sel_q),
   .cnt_q    (cnt_q)
);

// File: tb/sqwave_out_bench.sv
`timescale 1ns/1ps
module sqwave_out_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt = 1'b0;
   logic [7:0] ctrl = 8'h00;
   logic       pin_oe;

   always #2.5 clk = ~clk;   // 200 MHz

   sqwave_out u_sqwave_out (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .halt_i   (halt),
      .ctrl_i   (ctrl),
      .pin_oe_o (pin_oe)
   );

   int  k = 0;            // unhalted rising edges since reset
   int  nchecks = 0;
   int  nerrors = 0;
   bit  wave = 1'b0;
   bit  static_val = 1'b1;
   bit  hold_val = 1'b1;
   bit  cur_exp = 1'b1;
   int  t_cur = 0;
   int  kedge = 0;
   bit  done = 1'b0;

   always @(posedge clk) if (rst_n && !halt) k <= k + 1;

   function automatic int tap_of(input logic [1:0] rs);
      case (rs)
         2'b00:   return 15;
         2'b01:   return 3;
         2'b10:   return 2;
         default: return 0;
      endcase
   endfunction

   function automatic bit bit_of(input int kk, input int t);
      return bit'((kk >> t) & 1);
   endfunction

   function automatic logic [7:0] mk(input bit lvl, input bit en, input logic [1:0] rs,
                                     input logic [3:0] junk);
      return {lvl, junk[3:2], en, junk[1:0], rs};
   endfunction

   task automatic check(input string req, input bit act, input bit exp);
      nchecks++;
      if (act !== exp) begin
         nerrors++;
         $display("FAIL %s k=%0d actual level %0b expected %0b", req, k, act, exp);
      end
   endtask

   task automatic ticks(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!wave)          cur_exp = static_val;
         else if (k < kedge) cur_exp = hold_val;
         else                cur_exp = bit_of(k, t_cur);
         check(req, !pin_oe, cur_exp);
      end
   endtask

   // called right after a falling-edge sample
   task automatic go_wave(input logic [1:0] rs, input bit lvl, input logic [3:0] junk);
      hold_val = cur_exp;
      t_cur    = tap_of(rs);
      kedge    = ((k >> t_cur) + 1) << t_cur;
      wave     = 1'b1;
      ctrl     = mk(lvl, 1'b1, rs, junk);
   endtask

   task automatic go_static(input bit lvl, input logic [1:0] rs, input logic [3:0] junk);
      wave       = 1'b0;
      static_val = lvl;
      ctrl       = mk(lvl, 1'b0, rs, junk);
   endtask

   initial begin
      // R1: reset state, pin released
      repeat (3) begin
         @(negedge clk);
         check("R1 reset", pin_oe, 1'b0);
      end
      rst_n = 1'b1;
      go_static(1'b1, 2'b00, 4'h0);
      ticks("R2 static high", 4);
      go_static(1'b0, 2'b11, 4'hF);
      ticks("R3 unused bits static low", 4);
      check("R5 open drain low drives", pin_oe, 1'b1);
      go_static(1'b1, 2'b10, 4'hF);
      ticks("R2 static high junk", 4);
      check("R5 open drain high releases", pin_oe, 1'b0);
      // R8: static follows level while halted
      halt = 1'b1;
      go_static(1'b0, 2'b01, 4'h5);
      ticks("R8 static halted", 4);
      go_static(1'b1, 2'b01, 4'hA);
      ticks("R8 static halted", 4);
      halt = 1'b0;
      ticks("R8 static resume", 3);
      // R4 / R6: each rate, switching mid-stream
      go_wave(2'b11, 1'b0, 4'h0);
      ticks("R4 rate 11 tap0", 64);
      go_wave(2'b10, 1'b0, 4'h0);
      ticks("R6 switch to 10 tap2", 64);
      go_wave(2'b01, 1'b1, 4'h9);
      ticks("R6 switch to 01 tap3", 70);
      go_wave(2'b00, 1'b0, 4'h0);
      ticks("R6 switch to 00 tap15", kedge - k + 12);
      go_wave(2'b11, 1'b0, 4'h0);
      ticks("R6 switch to 11 tap0", 40);
      // R3: level and unused bits ignored in wave mode
      ctrl = mk(1'b1, 1'b1, 2'b11, 4'hF);
      ticks("R3 unused bits wave", 40);
      ctrl = mk(1'b0, 1'b1, 2'b11, 4'h6);
      ticks("R3 unused bits wave", 20);
      // R7: halt freezes the wave
      go_wave(2'b01, 1'b0, 4'h0);
      ticks("R6 switch to 01", 40);
      halt = 1'b1;
      ticks("R7 halted wave", 25);
      halt = 1'b0;
      ticks("R7 resume wave", 40);
      // R2: back to static, then re-enable
      go_static(1'b1, 2'b01, 4'h0);
      ticks("R2 disable high", 3);
      go_static(1'b0, 2'b01, 4'h0);
      ticks("R2 disable low", 3);
      go_wave(2'b10, 1'b0, 4'h0);
      ticks("R6 enable from static", 30);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         nchecks++;
         nerrors++;
         $display("FAIL watchdog R1 actual done=0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
         $finish;
      end
   end

endmodule